// File: doc/BRIEF.md
# Key-Protected System Control Register Bank

This block is a bank of 32-bit system control words behind a single-cycle, word-addressed read/write port that spans a 4 KB window. Software must present a 16-bit key before it can change configuration words. One key, written to a dedicated address, opens the bank. A different key, written to a second address, closes it again. The bank comes out of reset closed. A status word reports whether the bank is closed.

A one-bit control word at offset 0x0 is writable at all times. The configuration words come in three groups: a clock-generator group at 0x100–0x11C, a reset-control group at 0x200–0x258 and a memory-interface group at 0x600–0x620. Inside these groups, one word is read-only, one address is a hole and one address returns a fixed constant. The bank stores values only. Nothing in it acts on the hardware.

Every address that decodes to nothing, and every address that is not word aligned, reads as zero and ignores writes. Such an access raises a one-cycle error pulse.

Top module: `sysctl_keybank`

## Requirements
- R1: After reset the bank is closed (`locked`=1). The control bit is 0 and read data is 0. Words 0x100, 0x104 and 0x108 read 0x0001A008, word 0x10C reads 0x0000003F, and words 0x110, 0x114 and 0x118 read 0x00014000. Every other storage word reads 0.
- R2: A write to 0x004 closes the bank when bits 15:0 of the write data equal 0x767B, whatever the upper bits hold. Any other value leaves the lock state as it was.
- R3: A write to 0x008 opens the bank when bits 15:0 of the write data equal 0xDF0D, whatever the upper bits hold. Any other value leaves the lock state as it was.
- R4: A read of 0x00C returns the lock state in bit 0, with all other bits zero. A write to 0x00C changes nothing. Reads of 0x004 and 0x008 always return zero.
- R5: Offset 0x000 stores bit 0 of the write data whether the bank is open or closed. It reads back in bit 0, with all other bits zero.
- R6: While the bank is closed, a write to any storage word is discarded and the word keeps its value.
- R7: While the bank is open, the storage words take the full 32-bit write data and read it back. The storage words are 0x100–0x11C except 0x10C, 0x200–0x258, and 0x600–0x620 except 0x604.
- R8: Word 0x10C can be read but is never written, even when the bank is open.
- R9: Offset 0x604 is a hole. It reads zero, ignores writes and raises the error pulse. Its neighbours 0x600 and 0x608 behave as normal storage.
- R10: Offset 0x25C always reads 1, and writes to it are ignored.
- R11: An access to an unmapped or misaligned address reads zero and does not change any state. `acc_err` is high in the cycle after the access and only then. Mapped accesses never raise it.
- R12: Read data appears on `rd_data` one clock after the read request and holds until the next read. A write is visible to an access made in the very next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_en | input | 1 | Access request this cycle |
| bus_we | input | 1 | 1 = write, 0 = read |
| bus_addr | input | 12 | Byte address within the 4 KB window |
| bus_wdata | input | 32 | Write data |
| rd_data | output | 32 | Registered read data |
| acc_err | output | 1 | One-cycle pulse after an access to an unmapped or misaligned address |
| locked | output | 1 | Current lock state (1 = closed) |

## Verification
Every result of this block is due exactly one clock edge after the access that causes it. This covers `rd_data` after a read, `acc_err` after a bad address, and the new `locked` value after a key write. A stored word is therefore visible to a read issued in the next cycle.

The bench drives each access just after a falling edge. At the following falling edge it compares all three outputs with a behavioural model, which has already been advanced by that access. All three outputs are therefore compared on every clock, including idle cycles, where `rd_data` must hold its value and `acc_err` must be low.

// File: rtl/sysctl_pkg.sv
package sysctl_pkg;

  localparam int ADDR_W = 12;
  localparam int DATA_W = 32;
  localparam int KEY_W  = 16;

  // storage groups, packed back to back in one word array
  localparam int PLL_N  = 8;
  localparam int RST_N  = 23;
  localparam int DDR_N  = 9;
  localparam int NWORDS = PLL_N + RST_N + DDR_N;
  localparam int IDX_W  = $clog2(NWORDS);

  localparam logic [ADDR_W-1:0] CTL_ADDR   = ADDR_W'(12'h000);
  localparam logic [ADDR_W-1:0] LOCK_ADDR  = ADDR_W'(12'h004);
  localparam logic [ADDR_W-1:0] OPEN_ADDR  = ADDR_W'(12'h008);
  localparam logic [ADDR_W-1:0] STAT_ADDR  = ADDR_W'(12'h00C);
  localparam logic [ADDR_W-1:0] PLL_BASE   = ADDR_W'(12'h100);
  localparam logic [ADDR_W-1:0] PLL_END    = PLL_BASE + ADDR_W'(4 * PLL_N);
  localparam logic [ADDR_W-1:0] PLL_RO     = ADDR_W'(12'h10C);
  localparam logic [ADDR_W-1:0] RST_BASE   = ADDR_W'(12'h200);
  localparam logic [ADDR_W-1:0] RST_END    = RST_BASE + ADDR_W'(4 * RST_N);
  localparam logic [ADDR_W-1:0] ONE_ADDR   = ADDR_W'(12'h25C);
  localparam logic [ADDR_W-1:0] DDR_BASE   = ADDR_W'(12'h600);
  localparam logic [ADDR_W-1:0] DDR_END    = DDR_BASE + ADDR_W'(4 * DDR_N);
  localparam logic [ADDR_W-1:0] DDR_HOLE   = ADDR_W'(12'h604);

  localparam logic [KEY_W-1:0] KEY_CLOSE = 16'h767B;
  localparam logic [KEY_W-1:0] KEY_OPEN  = 16'hDF0D;

  typedef enum logic [2:0] {
    SEL_NONE, SEL_CTL, SEL_LOCK, SEL_OPEN, SEL_STAT, SEL_STORE, SEL_ONE
  } sel_e;

  typedef enum logic {LK_OPEN = 1'b0, LK_SHUT = 1'b1} lock_e;

  typedef struct packed {
    sel_e             sel;
    logic [IDX_W-1:0] idx;
    logic             ro;
  } dec_t;

  function automatic logic [DATA_W-1:0] word_reset(input int unsigned idx);
    if (idx < 3)      return DATA_W'(32'h0001_A008);
    else if (idx == 3) return DATA_W'(32'h0000_003F);
    else if (idx < 7) return DATA_W'(32'h0001_4000);
    else              return '0;
  endfunction

endpackage

// File: rtl/sysctl_decode.sv
module sysctl_decode
  import sysctl_pkg::*;
(
  input  logic [ADDR_W-1:0] addr_i,
  output dec_t              dec_o
);

  always_comb begin
    dec_o.sel = SEL_NONE;
    dec_o.idx = '0;
    dec_o.ro  = 1'b0;
    if (addr_i[1:0] == 2'b00) begin
      if (addr_i == CTL_ADDR) begin
        dec_o.sel = SEL_CTL;
      end else if (addr_i == LOCK_ADDR) begin
        dec_o.sel = SEL_LOCK;
      end else if (addr_i == OPEN_ADDR) begin
        dec_o.sel = SEL_OPEN;
      end else if (addr_i == STAT_ADDR) begin
        dec_o.sel = SEL_STAT;
      end else if (addr_i >= PLL_BASE && addr_i < PLL_END) begin
        dec_o.sel = SEL_STORE;
        dec_o.idx = IDX_W'((addr_i - PLL_BASE) >> 2);
        dec_o.ro  = (addr_i == PLL_RO);
      end else if (addr_i >= RST_BASE && addr_i < RST_END) begin
        dec_o.sel = SEL_STORE;
        dec_o.idx = IDX_W'((addr_i - RST_BASE) >> 2) + IDX_W'(PLL_N);
      end else if (addr_i == ONE_ADDR) begin
        dec_o.sel = SEL_ONE;
      end else if (addr_i >= DDR_BASE && addr_i < DDR_END && addr_i != DDR_HOLE) begin
        dec_o.sel = SEL_STORE;
        dec_o.idx = IDX_W'((addr_i - DDR_BASE) >> 2) + IDX_W'(PLL_N + RST_N);
      end
    end
  end

endmodule

// File: rtl/sysctl_lock.sv
module sysctl_lock
  import sysctl_pkg::*;
(
  input  logic             clk,
  input  logic             rst_n,
  input  logic             close_req_i,
  input  logic             open_req_i,
  input  logic [KEY_W-1:0] key_i,
  output logic             locked_o
);

  lock_e state_q, state_d;

  always_comb begin
    state_d = state_q;
    if (close_req_i && key_i == KEY_CLOSE) begin
      state_d = LK_SHUT;
    end else if (open_req_i && key_i == KEY_OPEN) begin
      state_d = LK_OPEN;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state_q <= LK_SHUT;
    else        state_q <= state_d;
  end

  assign locked_o = (state_q == LK_SHUT);

endmodule

// File: rtl/sysctl_store.sv
module sysctl_store
  import sysctl_pkg::*;
#(
  parameter int NW = NWORDS,
  parameter int DW = DATA_W,
  parameter int IW = IDX_W
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          wr_en_i,
  input  logic [IW-1:0] idx_i,
  input  logic [DW-1:0] wdata_i,
  output logic [DW-1:0] rdata_o
);

  logic [DW-1:0] words [NW];

  for (genvar g = 0; g < NW; g++) begin : g_word
    logic [DW-1:0] q;
    logic          en;
    assign en = wr_en_i && (idx_i == IW'(g));
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= DW'(word_reset(g));
      else if (en) q <= wdata_i;
    end
    assign words[g] = q;
  end

  always_comb begin
    rdata_o = '0;
    if (idx_i < IW'(NW)) rdata_o = words[idx_i];
  end

endmodule

// File: rtl/sysctl_keybank.sv
module sysctl_keybank
  import sysctl_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              bus_en,
  input  logic              bus_we,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic [DATA_W-1:0] bus_wdata,
  output logic [DATA_W-1:0] rd_data,
  output logic              acc_err,
  output logic              locked
);

  dec_t              dec;
  logic              wr_acc, rd_acc;
  logic              locked_q;
  logic              store_we;
  logic [DATA_W-1:0] store_rd;
  logic              ctl_q, ctl_d;
  logic [DATA_W-1:0] rd_mux, rd_q;
  logic              err_q, err_d;

  assign wr_acc = bus_en && bus_we;
  assign rd_acc = bus_en && !bus_we;

  sysctl_decode u_dec (
    .addr_i (bus_addr),
    .dec_o  (dec)
  );

  sysctl_lock u_lock (
    .clk         (clk),
    .rst_n       (rst_n),
    .close_req_i (wr_acc && dec.sel == SEL_LOCK),
    .open_req_i  (wr_acc && dec.sel == SEL_OPEN),
    .key_i       (bus_wdata[KEY_W-1:0]),
    .locked_o    (locked_q)
  );

  assign store_we = wr_acc && dec.sel == SEL_STORE && !dec.ro && !locked_q;

  sysctl_store #(.NW(NWORDS), .DW(DATA_W), .IW(IDX_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .wr_en_i (store_we),
    .idx_i   (dec.idx),
    .wdata_i (bus_wdata),
    .rdata_o (store_rd)
  );

  // control bit: writable regardless of lock
  always_comb begin
    ctl_d = ctl_q;
    if (wr_acc && dec.sel == SEL_CTL) ctl_d = bus_wdata[0];
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) ctl_q <= 1'b0;
    else        ctl_q <= ctl_d;
  end

  always_comb begin
    case (dec.sel)
      SEL_CTL:   rd_mux = {{(DATA_W-1){1'b0}}, ctl_q};
      SEL_STAT:  rd_mux = {{(DATA_W-1){1'b0}}, locked_q};
      SEL_STORE: rd_mux = store_rd;
      SEL_ONE:   rd_mux = {{(DATA_W-1){1'b0}}, 1'b1};
      default:   rd_mux = '0;
    endcase
  end

  assign err_d = bus_en && dec.sel == SEL_NONE;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)      rd_q <= '0;
    else if (rd_acc) rd_q <= rd_mux;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) err_q <= 1'b0;
    else        err_q <= err_d;
  end

  assign rd_data = rd_q;
  assign acc_err = err_q;
  assign locked  = locked_q;

endmodule

// File: rtl/sysctl_keybank_chk.sv
module sysctl_keybank_chk
  import sysctl_pkg::*;
(
  input logic              clk,
  input logic              rst_n,
  input logic              bus_en,
  input logic              bus_we,
  input logic [ADDR_W-1:0] bus_addr,
  input logic [DATA_W-1:0] bus_wdata,
  input logic [DATA_W-1:0] rd_data,
  input logic              acc_err,
  input logic              locked
);

  logic key_wr;
  assign key_wr = bus_en && bus_we && (bus_addr == LOCK_ADDR || bus_addr == OPEN_ADDR);

  assert_close_key_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == LOCK_ADDR && bus_wdata[KEY_W-1:0] == KEY_CLOSE) |=> locked);

  assert_open_key_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_we && bus_addr == OPEN_ADDR && bus_wdata[KEY_W-1:0] == KEY_OPEN) |=> !locked);

  // R2 R3: lock moves only on a key write
  assert_lock_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !key_wr |=> $stable(locked));

  assert_status_read_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == STAT_ADDR) |=> rd_data == {{(DATA_W-1){1'b0}}, $past(locked)});

  assert_key_read_zero_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && (bus_addr == LOCK_ADDR || bus_addr == OPEN_ADDR)) |=> rd_data == '0);

  assert_const_one_R10: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && !bus_we && bus_addr == ONE_ADDR) |=> rd_data == DATA_W'(1));

  assert_misaligned_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_addr[1:0] != 2'b00) |=> acc_err);

  assert_no_idle_err_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !bus_en |=> !acc_err);

  assert_hole_err_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_en && bus_addr == DDR_HOLE) |=> acc_err);

  assert_rd_hold_R12: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_en && !bus_we) |=> $stable(rd_data));

endmodule

bind sysctl_keybank sysctl_keybank_chk u_chk (
  .clk       (clk),
  .rst_n     (rst_n),
  .bus_en    (bus_en),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .rd_data   (rd_data),
  .acc_err   (acc_err),
  .locked    (locked)
);

// File: tb/sysctl_keybank_tb_top.sv
`timescale 1ns/1ps
module sysctl_keybank_tb_top;

  logic        clk = 1'b0;
  logic        rst_n;
  logic        bus_en;
  logic        bus_we;
  logic [11:0] bus_addr;
  logic [31:0] bus_wdata;
  logic [31:0] rd_data;
  logic        acc_err;
  logic        locked;

  always #2 clk = ~clk;

  sysctl_keybank dut_i (
    .clk       (clk),
    .rst_n     (rst_n),
    .bus_en    (bus_en),
    .bus_we    (bus_we),
    .bus_addr  (bus_addr),
    .bus_wdata (bus_wdata),
    .rd_data   (rd_data),
    .acc_err   (acc_err),
    .locked    (locked)
  );

  int n_chk = 0;
  int n_bad = 0;

  // behavioural reference
  logic [31:0] mirror [int];
  bit          m_ctl;
  bit          m_locked;
  logic [31:0] exp_rd;
  bit          exp_err;
  string       cur_tag;

  function automatic bit m_store(int a);
    if (a % 4 != 0) return 0;
    return (a >= 256 && a < 288) || (a >= 512 && a < 604) ||
           (a >= 1536 && a <= 1568 && a != 1540);
  endfunction

  function automatic bit m_mapped(int a);
    if (a % 4 != 0) return 0;
    return a <= 12 || a == 604 || m_store(a);
  endfunction

  function automatic logic [31:0] m_read(int a);
    if (a == 0)   return {31'b0, m_ctl};
    if (a == 12)  return {31'b0, m_locked};
    if (a == 604) return 32'd1;
    if (m_store(a)) return mirror.exists(a) ? mirror[a] : 32'd0;
    return 32'd0;
  endfunction

  task automatic m_reset();
    mirror.delete();
    for (int a = 256; a < 268; a += 4) mirror[a] = 32'h0001_A008;
    mirror[268] = 32'h0000_003F;
    for (int a = 272; a < 284; a += 4) mirror[a] = 32'h0001_4000;
    m_ctl = 0; m_locked = 1; exp_rd = 0; exp_err = 0;
  endtask

  task automatic m_apply(bit we, int a, logic [31:0] d);
    exp_err = !m_mapped(a);
    if (!we) begin
      exp_rd = m_read(a);
    end else begin
      if (a == 0) m_ctl = d[0];
      else if (a == 4 && d[15:0] == 16'h767B) m_locked = 1;
      else if (a == 8 && d[15:0] == 16'hDF0D) m_locked = 0;
      else if (m_store(a) && !m_locked && a != 268) mirror[a] = d;
    end
  endtask

  task automatic cmp();
    n_chk += 3;
    if (rd_data !== exp_rd) begin
      n_bad++;
      $display("FAIL %s rd_data actual=%h expected=%h", cur_tag, rd_data, exp_rd);
    end
    if (acc_err !== exp_err) begin
      n_bad++;
      $display("FAIL %s acc_err actual=%b expected=%b", cur_tag, acc_err, exp_err);
    end
    if (locked !== m_locked) begin
      n_bad++;
      $display("FAIL %s locked actual=%b expected=%b", cur_tag, locked, m_locked);
    end
  endtask

  // compare previous results, then advance model and drive next access
  task automatic step(bit en, bit we, logic [11:0] a, logic [31:0] d, string tag);
    @(negedge clk);
    cmp();
    cur_tag = tag;
    if (en) m_apply(we, int'(a), d);
    else    exp_err = 0;
    bus_en = en; bus_we = we; bus_addr = a; bus_wdata = d;
  endtask

  task automatic rd(logic [11:0] a, string tag);
    step(1, 0, a, 32'h0, tag);
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d, string tag);
    step(1, 1, a, d, tag);
  endtask

  task automatic idle(string tag);
    step(0, 0, 12'h0, 32'h0, tag);
  endtask

  task automatic finish_run();
    $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    n_bad++;
    $display("FAIL watchdog expired");
    finish_run();
  end

  initial begin
    rst_n = 0; bus_en = 0; bus_we = 0; bus_addr = '0; bus_wdata = '0;
    m_reset();
    cur_tag = "R1 reset state";
    repeat (3) @(negedge clk);
    rst_n = 1;

    // R1 reset values
    idle("R1 reset state");
    rd(12'h00C, "R1 R4 status after reset");
    rd(12'h100, "R1 pll ctrl reset");
    rd(12'h108, "R1 pll ctrl reset");
    rd(12'h10C, "R1 pll status reset");
    rd(12'h110, "R1 pll cfg reset");
    rd(12'h11C, "R1 zero reset");
    rd(12'h600, "R1 zero reset");
    rd(12'h000, "R1 control bit reset");
    // R4 key addresses read zero
    rd(12'h004, "R4 lock addr reads zero");
    rd(12'h008, "R4 unlock addr reads zero");
    // R5 control bit while closed
    wr(12'h000, 32'hFFFF_FFFF, "R5 ctl write while closed");
    rd(12'h000, "R5 ctl readback");
    // R6 closed writes discarded
    wr(12'h100, 32'h1234_5678, "R6 closed write");
    rd(12'h100, "R6 closed write discarded");
    wr(12'h600, 32'hCAFE_0001, "R6 closed write");
    rd(12'h600, "R6 closed write discarded");
    // R3 wrong key then right key with junk upper bits
    wr(12'h008, 32'h0000_DF0C, "R3 wrong open key");
    rd(12'h00C, "R3 still closed");
    wr(12'h004, 32'h0000_DF0D, "R3 open key at close addr");
    wr(12'h008, 32'h1234_DF0D, "R3 open key upper bits ignored");
    rd(12'h00C, "R3 R4 status open");
    // R4 status write ignored
    wr(12'h00C, 32'hFFFF_FFFF, "R4 status write ignored");
    rd(12'h00C, "R4 status unchanged");
    // R7 R12 write then immediate read
    wr(12'h100, 32'hDEAD_BEEF, "R7 write");
    rd(12'h100, "R7 R12 next cycle readback");
    wr(12'h11C, 32'h8000_0001, "R7 write");
    wr(12'h200, 32'h0F0F_F0F0, "R7 write");
    wr(12'h258, 32'hFFFF_FFFF, "R7 write");
    wr(12'h620, 32'h0000_0000, "R7 write");
    rd(12'h11C, "R7 readback");
    rd(12'h200, "R7 readback");
    rd(12'h258, "R7 readback");
    rd(12'h620, "R7 readback");
    // R8 read-only word
    wr(12'h10C, 32'h0000_0000, "R8 ro write");
    rd(12'h10C, "R8 ro unchanged");
    // R9 hole
    wr(12'h600, 32'h1111_1111, "R9 neighbour");
    wr(12'h604, 32'h2222_2222, "R9 hole write err");
    wr(12'h608, 32'h3333_3333, "R9 neighbour");
    rd(12'h604, "R9 hole reads zero");
    rd(12'h600, "R9 neighbour intact");
    rd(12'h608, "R9 neighbour intact");
    // R10 constant one
    wr(12'h25C, 32'h0000_0000, "R10 const write");
    rd(12'h25C, "R10 const reads one");
    // R11 unmapped / misaligned
    rd(12'h300, "R11 unmapped read");
    wr(12'hFFC, 32'hFFFF_FFFF, "R11 unmapped write");
    wr(12'h102, 32'h5555_5555, "R11 misaligned write");
    rd(12'h101, "R11 misaligned read");
    idle("R11 err one cycle");
    rd(12'h100, "R11 no state change");
    // R2 wrong then right close key
    wr(12'h004, 32'h0000_767A, "R2 wrong close key");
    rd(12'h00C, "R2 still open");
    wr(12'h004, 32'hABCD_767B, "R2 close key");
    rd(12'h00C, "R2 closed");
    wr(12'h000, 32'h0000_0000, "R5 ctl clear while closed");
    rd(12'h000, "R5 ctl readback");
    wr(12'h608, 32'h0, "R6 closed write");
    rd(12'h608, "R6 closed write discarded");
    // R12 hold across idle cycles
    idle("R12 rd_data holds");
    idle("R12 rd_data holds");
    // full window sweep while open
    wr(12'h008, 32'h0000_DF0D, "R3 reopen");
    for (int a = 0; a < 4096; a += 4)
      wr(12'(a), {a[15:0], ~a[15:0]}, "R7 R11 sweep write");
    for (int a = 0; a < 4096; a += 4)
      rd(12'(a), "R7 R11 sweep read");
    idle("R12 final");
    idle("R12 final");
    finish_run();
  end

endmodule